// File: doc/BRIEF.md
# Three-Process Shared Bus Scheduler

This control unit decides, cycle by cycle, which of three cooperating processes may touch a single shared memory bus. A synchronous `start` pulse arms all three processes. The writer process (process one) owns the bus in the first cycle of a run and is finished after that. The ready-gated reader (process two) spends one cycle initialising. It then waits until `xfer_ready` is high and reads the bus in that cycle. The free-bus reader (process three) keeps waiting for as long as another process holds the bus, and reads in the first cycle that nobody else claims it.

The grant vector is produced in the same cycle as the conditions that cause it, so `xfer_ready` acts on the grant without a register stage. Each process reports a one-cycle `done` pulse in the cycle after its access and then stays quiet until the next `start`. The controller carries no data. All control pins are plain levels with no handshake.

Top module: `busctl_top`

## Requirements
- R1: While `rst_n` is low, and after its release until the first `start`, `grant` and `done` are all zero whatever `xfer_ready` does.
- R2: In any cycle where `start` is high, `grant` is zero. The next cycle begins a fresh run with all three processes armed, and any run still in progress is abandoned.
- R3: In run cycle 0 (the cycle right after `start` was high), `grant` equals 3'b001 (process one, bit 0). Process three is held off in that cycle.
- R4: Process one (`grant[0]`) is never granted again in the same run.
- R5: Process two (`grant[1]`) is never granted in run cycle 0, even with `xfer_ready` high. From cycle 1 on, it is granted in the first cycle in which `xfer_ready` is high.
- R6: Process three (`grant[2]`) is granted in the first run cycle of 1 or later in which process two is not granted.
- R7: When process two and process three are both eligible in the same cycle, process two wins and process three moves to the next cycle.
- R8: At most one bit of `grant` is high in any cycle.
- R9: `done[i]` is high for exactly the cycle after `grant[i]` was high, and is zero otherwise.
- R10: Each process receives exactly one grant per run, provided `xfer_ready` eventually goes high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Synchronous re-arm of all three processes |
| xfer_ready | input | 1 | Transfer-ready condition awaited by process two |
| grant | output | 3 | Bus grant: bit 0 writer, bit 1 ready-gated reader, bit 2 free-bus reader |
| done | output | 3 | One-cycle completion pulse per process, same bit order |

## Verification
The first grant of a run is due one cycle after `start` is sampled. Later grants respond to `xfer_ready` within the same cycle, and each `done` bit is due exactly one cycle after its grant. The bench drives inputs on the falling edge and samples outputs 1 ns later. It compares both vectors in every cycle against a behavioural model that advances once per clock, so every check falls in the cycle in which its result is due. The scenarios cover ready held high, ready late, ready high only during initialisation, a restart in the middle of a run, and `start` held for two cycles.

// File: rtl/busctl_pkg.sv
package busctl_pkg;
  localparam int NPROC          = 3;
  localparam int IDX_WRITER     = 0;
  localparam int IDX_RDY_READER = 1;
  localparam int IDX_FREE_READER = 2;
  typedef logic [NPROC-1:0] pvec_t;
endpackage

// File: rtl/busctl_slot.sv
// Per-process run state: armed on start, retired on its grant, pulses done once.
module busctl_slot (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic granted,
  output logic pending,
  output logic done
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending <= 1'b0;
      done    <= 1'b0;
    end else if (start) begin
      pending <= 1'b1;
      done    <= 1'b0;
    end else begin
      if (granted) pending <= 1'b0;
      done <= granted;
    end
  end
endmodule

// File: rtl/busctl_phase.sv
// Counts run cycles up to the initialisation length of process two.
module busctl_phase #(
  parameter int INIT_CYCLES = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic init_over
);
  localparam int CW = (INIT_CYCLES < 1) ? 1 : $clog2(INIT_CYCLES + 1);
  localparam logic [CW-1:0] LIMIT = CW'(INIT_CYCLES);

  logic [CW-1:0] age_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             age_q <= LIMIT;
    else if (start)         age_q <= '0;
    else if (age_q != LIMIT) age_q <= age_q + 1'b1;
  end

  assign init_over = (age_q == LIMIT);
endmodule

// File: rtl/busctl_claims.sv
// Which armed processes want the bus in the current cycle.
module busctl_claims
  import busctl_pkg::*;
(
  input  pvec_t pending,
  input  logic  init_over,
  input  logic  xfer_ready,
  output pvec_t claim
);
  always_comb begin
    claim = '0;
    claim[IDX_WRITER]      = pending[IDX_WRITER];
    claim[IDX_RDY_READER]  = pending[IDX_RDY_READER] & init_over & xfer_ready;
    claim[IDX_FREE_READER] = pending[IDX_FREE_READER];
  end
endmodule

// File: rtl/busctl_arb.sv
// Fixed-priority single grant: lower index wins; a hold blocks everyone.
module busctl_arb #(
  parameter int N = 3
) (
  input  logic [N-1:0] claim,
  input  logic         hold,
  output logic [N-1:0] grant
);
  logic [N:0] taken;

  assign taken[0] = hold;

  for (genvar i = 0; i < N; i++) begin : g_chain
    assign grant[i]   = claim[i] & ~taken[i];
    assign taken[i+1] = taken[i] | claim[i];
  end
endmodule

// File: rtl/busctl_top.sv
module busctl_top
  import busctl_pkg::*;
#(
  parameter int P2_INIT_CYCLES = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             xfer_ready,
  output logic [NPROC-1:0] grant,
  output logic [NPROC-1:0] done
);
  pvec_t pending;
  pvec_t claim;
  logic  init_over;

  for (genvar p = 0; p < NPROC; p++) begin : g_slot
    busctl_slot u_slot (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (start),
      .granted (grant[p]),
      .pending (pending[p]),
      .done    (done[p])
    );
  end

  busctl_phase #(.INIT_CYCLES(P2_INIT_CYCLES)) u_phase (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .init_over (init_over)
  );

  busctl_claims u_claims (
    .pending    (pending),
    .init_over  (init_over),
    .xfer_ready (xfer_ready),
    .claim      (claim)
  );

  busctl_arb #(.N(NPROC)) u_arb (
    .claim (claim),
    .hold  (start),
    .grant (grant)
  );
endmodule

// File: rtl/busctl_chk.sv
module busctl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic [2:0] grant,
  input logic [2:0] done
);
  logic [2:0] seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     seen_q <= '0;
    else if (start) seen_q <= '0;
    else            seen_q <= seen_q | grant;
  end

  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(grant)); // R8
  AST_START_QUIET: assert property (@(posedge clk) disable iff (!rst_n) start |-> grant == 3'b000); // R2
  AST_FIRST_WRITER: assert property (@(posedge clk) disable iff (!rst_n) $past(start) && !start |-> grant == 3'b001); // R3
  AST_DONE_TRAILS: assert property (@(posedge clk) disable iff (!rst_n) done == $past(grant)); // R9
  AST_ONCE_PER_RUN: assert property (@(posedge clk) disable iff (!rst_n) (grant & seen_q) == 3'b000); // R10
endmodule

bind busctl_top busctl_chk u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .start (start),
  .grant (grant),
  .done  (done)
);

// File: tb/busctl_top_bench.sv
`timescale 1ns/1ps
module busctl_top_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic       xfer_ready = 1'b0;
  logic [2:0] grant;
  logic [2:0] done;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // behavioural reference state
  bit [2:0] m_pend = '0;
  bit [2:0] m_done = '0;
  int       m_age  = 1000;

  always #2.5 clk = ~clk;

  busctl_top u_busctl_top (
    .clk(clk), .rst_n(rst_n), .start(start), .xfer_ready(xfer_ready),
    .grant(grant), .done(done)
  );

  task automatic check(input string tag, input string what, input logic [2:0] act, input logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%b expected=%b at %0t", tag, what, act, exp, $time);
    end
  endtask

  // One clock cycle: drive inputs, compare against model, advance model.
  task automatic step(input bit s, input bit r, input string tag);
    bit [2:0] g;
    @(negedge clk);
    start = s;
    xfer_ready = r;
    #1;
    g = '0;
    if (!s) begin
      if (m_pend[0])                       g = 3'b001;
      else if (m_pend[1] && m_age >= 1 && r) g = 3'b010;
      else if (m_pend[2])                  g = 3'b100;
    end
    check(tag, "grant", grant, g);
    check(tag, "done", done, m_done);
    check("R8", "onehot", 3'(($countones(grant) <= 1) ? 1 : 0), 3'd1);
    if (s) begin
      m_pend = 3'b111; m_age = 0; m_done = '0;
    end else begin
      m_pend = m_pend & ~g; m_done = g; m_age++;
    end
  endtask

  initial begin
    // R1: reset state
    repeat (3) begin
      @(negedge clk); xfer_ready = ~xfer_ready; #1;
      check("R1", "grant in reset", grant, 3'b000);
      check("R1", "done in reset", done, 3'b000);
    end
    @(negedge clk); rst_n = 1'b1;
    for (int i = 0; i < 4; i++) step(1'b0, i[0], "R1");

    // R3 R4 R7 R9: ready always high -> writer, then reader two beats reader three
    step(1'b1, 1'b1, "R2");
    step(1'b0, 1'b1, "R3");
    step(1'b0, 1'b1, "R7");
    for (int i = 0; i < 4; i++) step(1'b0, 1'b1, "R4");

    // R5 R6: ready late -> reader three goes in cycle 1, reader two waits
    step(1'b1, 1'b0, "R2");
    step(1'b0, 1'b0, "R3");
    step(1'b0, 1'b0, "R6");
    for (int i = 0; i < 3; i++) step(1'b0, 1'b0, "R5");
    step(1'b0, 1'b1, "R5");
    for (int i = 0; i < 3; i++) step(1'b0, 1'b1, "R10");

    // R5: ready high only during initialisation is ignored
    step(1'b1, 1'b1, "R2");
    step(1'b0, 1'b1, "R5");
    step(1'b0, 1'b0, "R6");
    step(1'b0, 1'b0, "R5");
    step(1'b0, 1'b1, "R5");
    step(1'b0, 1'b1, "R9");

    // R2: restart in the middle of a run
    step(1'b1, 1'b0, "R2");
    step(1'b0, 1'b0, "R3");
    step(1'b1, 1'b1, "R2");
    step(1'b0, 1'b1, "R3");
    step(1'b0, 1'b1, "R7");
    step(1'b0, 1'b1, "R6");
    step(1'b0, 1'b1, "R9");

    // R2: start held for two cycles
    step(1'b1, 1'b1, "R2");
    step(1'b1, 1'b1, "R2");
    step(1'b0, 1'b0, "R3");
    step(1'b0, 1'b0, "R6");
    step(1'b0, 1'b1, "R5");
    for (int i = 0; i < 3; i++) step(1'b0, 1'b1, "R10");

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #20000;
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule